// File: doc/BRIEF.md
# Cache Lockdown Victim Way Selector

This block picks the way of a set-associative cache (one to four ways) that receives each line fill. It also lets software lock whole ways so their contents stay resident. A 32-bit control register holds two fields: a load-enable flag and a way index. With the flag set, every fill lands in the indexed way, so software can load lines into a chosen way. With the flag clear, the ways numbered below the index are locked. Replacement then rotates round-robin over the index and the ways above it.

To lock a way, software sets load-enable with the target index, reads the lines it wants to keep (one 32-byte, 8-word line per fill), and then writes load-enable = 0 with the index one past the loaded way. To lock several ways, it steps the index with load-enable still set and clears the flag only after the last way is loaded. At least one way always stays free. In a direct-mapped cache the index is therefore pinned to 0.

Top module: `lkd_victim_sel`

## Requirements
- R1: After synchronous reset, cfg_rd_data reads 0 (load-enable clear, index 0, all ways unlocked) and the first normal-mode fill goes to way 0.
- R2: A write with cfg_wr_en high takes bit 31 as load-enable and bits [1:0] as the way index, and cfg_rd_data shows them from the next cycle. All other written bits are ignored and read back as 0.
- R3: A written index greater than (effective ways − 1) is stored and read back as (effective ways − 1), so at least one way stays unlocked.
- R4: num_ways gives the way count. A value of 0 counts as 1 way and any value above 4 counts as 4 ways. fill_way never exceeds (effective ways − 1).
- R5: While load-enable is 1, every fill goes to the indexed way, and the round-robin pointer does not move.
- R6: While load-enable is 0, successive fills take the next way each time. After the top way (effective ways − 1), the next fill goes back to the index way.
- R7: While load-enable is 0, fill_way is never below the index. If the pointer lies below the index or beyond the top way, the fill goes to the index way.
- R8: fill_way is valid in the same cycle as fill_req. The pointer moves only on a cycle with fill_req high and load-enable 0.
- R9: With one effective way, every fill goes to way 0 whatever is written, and the index reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| num_ways | input | 3 | Way count of the cache, static in use |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value |
| cfg_rd_data | output | 32 | Control register contents |
| fill_req | input | 1 | Line fill request, one per cycle |
| fill_way | output | 2 | Way that takes the fill requested this cycle |

## Verification
fill_way depends only on state held in registers, so it is due in the same cycle as fill_req. The bench samples it one nanosecond after the falling edge that raised the request, before the rising edge moves the pointer. A register write becomes visible on cfg_rd_data after the rising edge that takes it, so every readback is sampled in a cycle after the write cycle. The driver predicts each result when it issues the stimulus and queues it. The monitor pops the queue only in cycles where a fill or a readback is marked, so each result is compared in the cycle it is due.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam int unsigned LKD_MAX_WAYS = 4;
  localparam int unsigned LKD_WAY_W    = 2;
  localparam int unsigned LKD_NW_W     = 3;
  localparam int unsigned LKD_REG_W    = 32;
  localparam int unsigned LKD_LOAD_BIT = 31;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_LOAD   = 1'b1
  } lkd_mode_e;
endpackage

// File: rtl/lkd_ways_sat.sv
module lkd_ways_sat #(
  parameter int unsigned MAX_WAYS = lkd_pkg::LKD_MAX_WAYS,
  parameter int unsigned NW_W     = lkd_pkg::LKD_NW_W,
  parameter int unsigned WAY_W    = lkd_pkg::LKD_WAY_W
) (
  input  logic [NW_W-1:0]  num_ways,
  output logic [WAY_W-1:0] last_way
);
  localparam logic [NW_W-1:0] MAX_N = NW_W'(MAX_WAYS);
  localparam logic [NW_W-1:0] ONE_N = NW_W'(1);

  logic [NW_W-1:0] ways_eff;
  logic [NW_W-1:0] top_n;
  logic            unused_top_bits;

  always_comb begin
    if (num_ways == '0) begin
      ways_eff = ONE_N;
    end else if (num_ways > MAX_N) begin
      ways_eff = MAX_N;
    end else begin
      ways_eff = num_ways;
    end
  end

  assign top_n           = ways_eff - ONE_N;
  assign last_way        = top_n[WAY_W-1:0];
  assign unused_top_bits = ^top_n;
endmodule

// File: rtl/lkd_ctrl_reg.sv
module lkd_ctrl_reg #(
  parameter int unsigned REG_W    = lkd_pkg::LKD_REG_W,
  parameter int unsigned WAY_W    = lkd_pkg::LKD_WAY_W,
  parameter int unsigned LOAD_BIT = lkd_pkg::LKD_LOAD_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [WAY_W-1:0] last_way,
  output logic             load_en,
  output logic [WAY_W-1:0] way_idx,
  output logic [REG_W-1:0] rd_data
);
  logic [WAY_W-1:0] wr_idx;
  logic [WAY_W-1:0] wr_idx_sat;
  logic             unused_wr_bits;

  assign wr_idx         = wr_data[WAY_W-1:0];
  assign wr_idx_sat     = (wr_idx > last_way) ? last_way : wr_idx;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en <= 1'b0;
      way_idx <= '0;
    end else if (wr_en) begin
      load_en <= wr_data[LOAD_BIT];
      way_idx <= wr_idx_sat;
    end
  end

  always_comb begin
    rd_data                = '0;
    rd_data[LOAD_BIT]      = load_en;
    rd_data[WAY_W-1:0]     = way_idx;
  end
endmodule

// File: rtl/lkd_rr_pick.sv
module lkd_rr_pick #(
  parameter int unsigned MAX_WAYS = lkd_pkg::LKD_MAX_WAYS,
  parameter int unsigned WAY_W    = lkd_pkg::LKD_WAY_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fill_req,
  input  lkd_pkg::lkd_mode_e  mode,
  input  logic [WAY_W-1:0]    way_idx,
  input  logic [WAY_W-1:0]    last_way,
  output logic [WAY_W-1:0]    victim
);
  logic [WAY_W-1:0]    rr_q;
  logic [WAY_W-1:0]    base_idx;
  logic [MAX_WAYS-1:0] free_mask;
  logic                rr_free;
  logic [WAY_W-1:0]    rr_next;

  assign base_idx = (way_idx > last_way) ? last_way : way_idx;

  for (genvar g = 0; g < MAX_WAYS; g++) begin : g_free
    localparam logic [WAY_W-1:0] GW = WAY_W'(g);
    assign free_mask[g] = (GW >= base_idx) && (GW <= last_way);
  end

  assign rr_free = free_mask[rr_q];

  always_comb begin
    if (mode == lkd_pkg::MODE_LOAD) begin
      victim = base_idx;
    end else if (rr_free) begin
      victim = rr_q;
    end else begin
      victim = base_idx;
    end
  end

  assign rr_next = (victim == last_way) ? base_idx : victim + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_req && (mode == lkd_pkg::MODE_NORMAL)) begin
      rr_q <= rr_next;
    end
  end
endmodule

// File: rtl/lkd_victim_sel.sv
module lkd_victim_sel #(
  parameter int unsigned MAX_WAYS = lkd_pkg::LKD_MAX_WAYS,
  parameter int unsigned WAY_W    = lkd_pkg::LKD_WAY_W,
  parameter int unsigned NW_W     = lkd_pkg::LKD_NW_W,
  parameter int unsigned REG_W    = lkd_pkg::LKD_REG_W,
  parameter int unsigned LOAD_BIT = lkd_pkg::LKD_LOAD_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW_W-1:0]  num_ways,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             fill_req,
  output logic [WAY_W-1:0] fill_way
);
  logic               load_en;
  logic [WAY_W-1:0]   way_idx;
  logic [WAY_W-1:0]   last_way;
  lkd_pkg::lkd_mode_e mode;

  lkd_ways_sat #(
    .MAX_WAYS (MAX_WAYS),
    .NW_W     (NW_W),
    .WAY_W    (WAY_W)
  ) sat_i (
    .num_ways (num_ways),
    .last_way (last_way)
  );

  lkd_ctrl_reg #(
    .REG_W    (REG_W),
    .WAY_W    (WAY_W),
    .LOAD_BIT (LOAD_BIT)
  ) reg_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .last_way (last_way),
    .load_en  (load_en),
    .way_idx  (way_idx),
    .rd_data  (cfg_rd_data)
  );

  assign mode = load_en ? lkd_pkg::MODE_LOAD : lkd_pkg::MODE_NORMAL;

  lkd_rr_pick #(
    .MAX_WAYS (MAX_WAYS),
    .WAY_W    (WAY_W)
  ) pick_i (
    .clk      (clk),
    .rst      (rst),
    .fill_req (fill_req),
    .mode     (mode),
    .way_idx  (way_idx),
    .last_way (last_way),
    .victim   (fill_way)
  );
endmodule

// File: rtl/lkd_victim_sel_chk.sv
module lkd_victim_sel_chk #(
  parameter int unsigned MAX_WAYS = lkd_pkg::LKD_MAX_WAYS,
  parameter int unsigned WAY_W    = lkd_pkg::LKD_WAY_W,
  parameter int unsigned NW_W     = lkd_pkg::LKD_NW_W,
  parameter int unsigned REG_W    = lkd_pkg::LKD_REG_W,
  parameter int unsigned LOAD_BIT = lkd_pkg::LKD_LOAD_BIT
) (
  input logic             clk,
  input logic             rst,
  input logic [NW_W-1:0]  num_ways,
  input logic             cfg_wr_en,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             fill_req,
  input logic [WAY_W-1:0] fill_way
);
  logic [WAY_W-1:0] chk_last;
  logic             chk_ld;
  logic [WAY_W-1:0] chk_idx;
  logic             unused_chk;

  always_comb begin
    if (num_ways == '0) chk_last = '0;
    else if (num_ways >= NW_W'(MAX_WAYS)) chk_last = WAY_W'(MAX_WAYS - 1);
    else chk_last = WAY_W'(num_ways - NW_W'(1));
  end

  assign chk_ld     = cfg_rd_data[LOAD_BIT];
  assign chk_idx    = cfg_rd_data[WAY_W-1:0];
  assign unused_chk = ^cfg_wr_data;

  AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> (fill_way <= chk_last)); // R4

  AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (rst)
    (fill_req && chk_ld && (chk_idx <= chk_last)) |-> (fill_way == chk_idx)); // R5

  AST_LOCKED_AVOIDED: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !chk_ld && (chk_idx <= chk_last)) |-> (fill_way >= chk_idx)); // R7

  AST_IDX_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_wr_en) && $stable(num_ways)) |-> (chk_idx <= chk_last)); // R3

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[LOAD_BIT-1:WAY_W] == '0)); // R2

  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fill_req && !chk_ld && $stable(num_ways) &&
     $past(fill_req && !chk_ld && !cfg_wr_en && (fill_way != chk_last)))
    |-> (fill_way == $past(fill_way) + 1'b1)); // R6

  AST_DIRECT_MAPPED: assert property (@(posedge clk) disable iff (rst)
    (fill_req && (chk_last == '0)) |-> (fill_way == '0)); // R9
endmodule

bind lkd_victim_sel lkd_victim_sel_chk #(
  .MAX_WAYS (MAX_WAYS),
  .WAY_W    (WAY_W),
  .NW_W     (NW_W),
  .REG_W    (REG_W),
  .LOAD_BIT (LOAD_BIT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .num_ways    (num_ways),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .fill_req    (fill_req),
  .fill_way    (fill_way)
);

// File: tb/lkd_victim_sel_tb_top.sv
module lkd_victim_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  num_ways = 3'd4;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        fill_req = 1'b0;
  logic [1:0]  fill_way;
  logic        chk_rd = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];

  int m_last = 3;
  int m_idx  = 0;
  int m_ld   = 0;
  int m_rr   = 0;

  always #2 clk = ~clk;

  lkd_victim_sel dut_i (
    .clk         (clk),
    .rst         (rst),
    .num_ways    (num_ways),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .fill_req    (fill_req),
    .fill_way    (fill_way)
  );

  task automatic set_ways(input int n);
    num_ways = 3'(n);
    m_last = (n == 0) ? 0 : ((n > 4) ? 3 : n - 1);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    int wi;
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    wi = int'(d[1:0]);
    m_ld = int'(d[31]);
    m_idx = (wi > m_last) ? m_last : wi;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_wr_data = '0;
  endtask

  task automatic rd_chk(input string r);
    sb_item_t it;
    it.is_rd = 1'b1;
    it.exp = '0;
    it.exp[31] = m_ld[0];
    it.exp[1:0] = 2'(m_idx);
    it.req = r;
    sb_q.push_back(it);
    chk_rd = 1'b1;
    @(negedge clk);
    chk_rd = 1'b0;
  endtask

  task automatic fill(input string r);
    sb_item_t it;
    int v;
    if (m_ld != 0) v = m_idx;
    else if (m_rr < m_idx || m_rr > m_last) v = m_idx;
    else v = m_rr;
    if (m_ld == 0) m_rr = (v == m_last) ? m_idx : v + 1;
    it.is_rd = 1'b0;
    it.exp = 32'(v);
    it.req = r;
    sb_q.push_back(it);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (fill_req || chk_rd) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_fails++;
        $display("FAIL scoreboard: result with no expectation, got way %0d reg %h", fill_way, cfg_rd_data);
      end else begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_rd ? cfg_rd_data : {30'd0, fill_way};
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: %s got %h expected %h", it.req,
                   it.is_rd ? "readback" : "fill way", act, it.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, then first normal fill lands in way 0
    rd_chk("R1");
    fill("R1");
    // R6: round robin over four ways, wrapping to index 0
    fill("R6"); fill("R6"); fill("R6"); fill("R6");

    // R5: load mode into way 0, pointer held
    wr(32'h8000_0000);
    rd_chk("R2");
    fill("R5"); fill("R5");
    // R2/R6/R8: lock way 0, pointer resumes at 1 and wraps to index 1
    wr(32'h0000_0001);
    rd_chk("R2");
    fill("R8"); fill("R6"); fill("R6"); fill("R6");

    // R5: load ways 1 and 2 in turn with load-enable kept set
    wr(32'h8000_0001);
    fill("R5");
    wr(32'h8000_0002);
    fill("R5");
    // R7: lock ways 0..2, pointer below index goes to way 3
    wr(32'h0000_0003);
    rd_chk("R2");
    fill("R7"); fill("R7");

    // R2: bits other than 31 and [1:0] are ignored
    wr(32'h7FFF_FFFE);
    rd_chk("R2");
    fill("R7");

    // R3: index clamped with two ways
    set_ways(2);
    wr(32'h0000_0003);
    rd_chk("R3");
    fill("R3"); fill("R3");

    // R9: direct mapped
    set_ways(1);
    wr(32'h8000_0002);
    rd_chk("R9");
    fill("R9");
    wr(32'h0000_0003);
    rd_chk("R9");
    fill("R9"); fill("R9");

    // R4: zero ways counts as one
    set_ways(0);
    wr(32'h0000_0001);
    rd_chk("R4");
    fill("R4");

    // R4: seven ways counts as four
    set_ways(7);
    wr(32'h0000_0003);
    rd_chk("R4");
    wr(32'h0000_0000);
    fill("R4"); fill("R4"); fill("R4"); fill("R4"); fill("R4");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule